// File: doc/BRIEF.md
# Dual Tightly Coupled Memory Router

This block sits between a processor's load/store port and the system bus. It holds two small on-chip arrays: an instruction region and a data region. For every access it decides which of three targets serves it: one of the two arrays or the external bus. Each region has a base address input. Each region also takes an enable bit and a load-mode bit from a 32-bit control word. A region in load mode still captures writes to its window, but it no longer answers reads. Those reads fall through to the next candidate.

Requests arrive on a valid/ready port with a size code, an address and right-justified write data. An access served by an array completes with a response one cycle after acceptance. An access that falls through is issued on a valid/ready bus port with byte enables and lane-replicated write data. The router then waits for the bus to signal completion. Only one access is in flight at a time.

Top module: `tcm_router`

## Requirements
- R1: The instruction region is checked first, then the data region. The access goes to the external bus only when neither region claims it.
- R2: A region claims an access only when it is enabled and base <= address < base + region size (unsigned, no wrap past 2^32). Both boundaries are exact.
- R3: The array location is the address ANDed with (size - 1). A base that is not a multiple of the size therefore still maps consistently, and stored bytes mirror within the window.
- R4: With a region's load-mode bit set, reads of its window are not served by it and go to the data region or the bus. Writes to its window are still stored in it.
- R5: A disabled region serves neither reads nor writes. Those accesses reach the bus, and the region's contents are left unchanged.
- R6: Control word bit 16 enables the data region and bit 17 sets data load mode. Bit 18 enables the instruction region and bit 19 sets instruction load mode. All other control bits have no effect on routing.
- R7: After reset, every byte of both arrays reads as zero. req_ready is high, and rsp_valid and bus_valid are low.
- R8: req_size 0 is a byte, 1 a halfword and 2 a word. Data is little-endian. Write data is taken from the low bits of req_wdata, and read data is returned zero-extended in the low bits of rsp_rdata.
- R9: An array-served access gives rsp_valid exactly one cycle after acceptance, with read data from that cycle's array contents.
- R10: A bus access holds bus_valid, bus_addr, bus_write, bus_be and bus_wdata steady until bus_ready. bus_be is 1<<a[1:0] for bytes, 3<<(2*a[1]) for halfwords and 4'hF for words. Write bytes are replicated into every lane. rsp_valid follows bus_rsp_valid in the same cycle, and the lane at the access offset is extracted from bus_rsp_data.
- R11: From acceptance of a bus access until its response, req_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 32 | Control word holding enable and load-mode bits |
| inst_base | input | 32 | Instruction region base address |
| data_base | input | 32 | Data region base address |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Router can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | Access completed |
| rsp_rdata | output | 32 | Zero-extended read data |
| bus_valid | output | 1 | External bus request valid |
| bus_ready | input | 1 | External bus takes the request |
| bus_write | output | 1 | External bus write |
| bus_addr | output | 32 | External bus byte address |
| bus_be | output | 4 | External bus byte enables |
| bus_wdata | output | 32 | Lane-replicated write data |
| bus_rsp_valid | input | 1 | External bus completion |
| bus_rsp_data | input | 32 | External bus read word (lane aligned) |

## Verification
The assertions assume three things about the inputs. Halfword and word addresses are naturally aligned. The requester holds no second request while a bus access is pending. The bus raises bus_rsp_valid only after it has taken a request. The stimulus aligns every address to its size inside the access task and never drives req_valid until the previous response has been seen. Its bus responder answers exactly once per taken request, after a varying gap of zero to two cycles. Because the regions are made small, the sweeps can walk every byte offset, every size and both window edges.

// File: rtl/tcm_router_pkg.sv
`timescale 1ns/1ps
// Shared types and lane helpers for the tightly coupled memory router.
// Assumes a 32-bit little-endian data path with naturally aligned accesses.
package tcm_router_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    // Control word bit positions (routing depends on them)
    localparam int CTL_DATA_ON   = 16;
    localparam int CTL_DATA_LOAD = 17;
    localparam int CTL_INST_ON   = 18;
    localparam int CTL_INST_LOAD = 19;

    // Byte enables for an access of the given size at the given offset
    function automatic logic [3:0] lane_mask(acc_size_e sz, logic [1:0] lo);
        case (sz)
            SZ_BYTE: lane_mask = 4'b0001 << lo;
            SZ_HALF: lane_mask = 4'b0011 << {lo[1], 1'b0};
            default: lane_mask = 4'b1111;
        endcase
    endfunction

    // Replicates right-justified write data into every lane
    function automatic logic [31:0] lane_fill(acc_size_e sz, logic [31:0] d);
        case (sz)
            SZ_BYTE: lane_fill = {4{d[7:0]}};
            SZ_HALF: lane_fill = {2{d[15:0]}};
            default: lane_fill = d;
        endcase
    endfunction

    // Extracts and zero-extends the addressed lanes of a word
    function automatic logic [31:0] lane_pick(acc_size_e sz, logic [1:0] lo, logic [31:0] w);
        logic [31:0] sh;
        sh = w >> {lo, 3'b000};
        case (sz)
            SZ_BYTE: lane_pick = {24'd0, sh[7:0]};
            SZ_HALF: lane_pick = {16'd0, sh[15:0]};
            default: lane_pick = sh;
        endcase
    endfunction

endpackage

// File: rtl/tcm_region.sv
`timescale 1ns/1ps
// One tightly coupled memory region: window decode plus a word array with
// byte-lane writes and a registered read port.
// Assumes SIZE_BYTES is a power of two of at least 8. The array index is the
// address masked by SIZE_BYTES-1, so any base mirrors consistently.
module tcm_region #(
    parameter int SIZE_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        load_mode,
    input  logic [31:0] base,
    input  logic [31:0] addr,
    output logic        claim_rd,
    output logic        claim_wr,
    input  logic        rd_strobe,
    input  logic        wr_strobe,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    localparam int WORDS = SIZE_BYTES / 4;
    localparam int IDX_W = $clog2(WORDS);

    logic [31:0]      mem [WORDS];
    logic [31:0]      rdata_q;
    logic [IDX_W-1:0] idx;
    logic             in_win;
    logic [32:0]      win_end;

    // Window test done in 33 bits so a window near the top cannot wrap
    always_comb begin
        win_end = {1'b0, base} + 33'(SIZE_BYTES);
        in_win  = ({1'b0, addr} >= {1'b0, base}) && ({1'b0, addr} < win_end);
    end

    assign idx      = addr[IDX_W+1:2];
    assign claim_wr = en && in_win;
    assign claim_rd = en && !load_mode && in_win;
    assign rdata    = rdata_q;

    // Array storage: cleared on reset, byte-lane writes otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_strobe) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (rd_strobe) rdata_q <= mem[idx];
    end

    // R4
    rd_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> (en && !load_mode && !wr_strobe));

    // R5
    wr_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> (en && !rd_strobe));
endmodule

// File: rtl/tcm_bus_port.sv
`timescale 1ns/1ps
// External bus side of the router: captures a fall-through access, holds it
// on a valid/ready request until taken, then waits for the completion strobe.
// Assumes the bus signals completion only after it has taken the request.
module tcm_bus_port (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        write,
    input  logic [31:0] addr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic        busy,
    output logic        done,
    output logic [31:0] rword,
    output logic        bus_valid,
    input  logic        bus_ready,
    output logic        bus_write,
    output logic [31:0] bus_addr,
    output logic [3:0]  bus_be,
    output logic [31:0] bus_wdata,
    input  logic        bus_rsp_valid,
    input  logic [31:0] bus_rsp_data
);
    typedef enum logic [1:0] {BP_IDLE, BP_ISSUE, BP_WAIT} bp_state_e;

    bp_state_e   state_q;
    logic        wr_q;
    logic [31:0] addr_q;
    logic [3:0]  be_q;
    logic [31:0] wdata_q;

    // Request sequencing: idle -> issue -> wait -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BP_IDLE;
        end else begin
            case (state_q)
                BP_IDLE:  if (start)         state_q <= BP_ISSUE;
                BP_ISSUE: if (bus_ready)     state_q <= BP_WAIT;
                BP_WAIT:  if (bus_rsp_valid) state_q <= BP_IDLE;
                default:                     state_q <= BP_IDLE;
            endcase
        end
    end

    // Request fields captured at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
        end else if (start && state_q == BP_IDLE) begin
            wr_q    <= write;
            addr_q  <= addr;
            be_q    <= be;
            wdata_q <= wdata;
        end
    end

    assign busy      = (state_q != BP_IDLE);
    assign done      = (state_q == BP_WAIT) && bus_rsp_valid;
    assign rword     = bus_rsp_data;
    assign bus_valid = (state_q == BP_ISSUE);
    assign bus_write = wr_q;
    assign bus_addr  = addr_q;
    assign bus_be    = be_q;
    assign bus_wdata = wdata_q;

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_be)
                                       && $stable(bus_wdata) && $stable(bus_write)));

    // R11
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/tcm_router.sv
`timescale 1ns/1ps
// Routes each load/store access to the instruction array, the data array or
// the external bus, in that priority. Arrays answer one cycle after
// acceptance; bus accesses complete on the bus completion strobe.
// Assumes naturally aligned halfword/word accesses and one access in flight.
module tcm_router
    import tcm_router_pkg::*;
#(
    parameter int INST_BYTES = 4096,
    parameter int DATA_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ctrl_word,
    input  logic [31:0] inst_base,
    input  logic [31:0] data_base,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        bus_valid,
    input  logic        bus_ready,
    output logic        bus_write,
    output logic [31:0] bus_addr,
    output logic [3:0]  bus_be,
    output logic [31:0] bus_wdata,
    input  logic        bus_rsp_valid,
    input  logic [31:0] bus_rsp_data
);
    acc_size_e   size_e;
    logic [3:0]  be;
    logic [31:0] wlanes;
    logic        accept;
    logic        i_claim_rd, i_claim_wr, d_claim_rd, d_claim_wr;
    logic        i_take, d_take, bus_take;
    logic        i_rd, i_wr, d_rd, d_wr;
    logic [31:0] i_word, d_word, bus_word;
    logic        bus_busy, bus_done;
    logic        loc_rsp_q, src_inst_q, wr_q;
    acc_size_e   size_q;
    logic [1:0]  lo_q;
    logic        unused_ctrl;

    assign unused_ctrl = ^{ctrl_word[31:20], ctrl_word[15:0]};

    // Lane formatting of the incoming request
    always_comb begin
        size_e = acc_size_e'(req_size);
        be     = lane_mask(size_e, req_addr[1:0]);
        wlanes = lane_fill(size_e, req_wdata);
    end

    tcm_region #(.SIZE_BYTES(INST_BYTES)) u_inst (
        .clk(clk), .rst_n(rst_n),
        .en(ctrl_word[CTL_INST_ON]), .load_mode(ctrl_word[CTL_INST_LOAD]),
        .base(inst_base), .addr(req_addr),
        .claim_rd(i_claim_rd), .claim_wr(i_claim_wr),
        .rd_strobe(i_rd), .wr_strobe(i_wr),
        .be(be), .wdata(wlanes), .rdata(i_word)
    );

    tcm_region #(.SIZE_BYTES(DATA_BYTES)) u_data (
        .clk(clk), .rst_n(rst_n),
        .en(ctrl_word[CTL_DATA_ON]), .load_mode(ctrl_word[CTL_DATA_LOAD]),
        .base(data_base), .addr(req_addr),
        .claim_rd(d_claim_rd), .claim_wr(d_claim_wr),
        .rd_strobe(d_rd), .wr_strobe(d_wr),
        .be(be), .wdata(wlanes), .rdata(d_word)
    );

    // Fixed-priority target choice: instruction, then data, then bus
    always_comb begin
        accept   = req_valid && req_ready;
        i_take   = req_write ? i_claim_wr : i_claim_rd;
        d_take   = !i_take && (req_write ? d_claim_wr : d_claim_rd);
        bus_take = !i_take && !d_take;
        i_rd     = accept && !req_write && i_take;
        i_wr     = accept &&  req_write && i_take;
        d_rd     = accept && !req_write && d_take;
        d_wr     = accept &&  req_write && d_take;
    end

    tcm_bus_port u_bus (
        .clk(clk), .rst_n(rst_n),
        .start(accept && bus_take), .write(req_write), .addr(req_addr),
        .be(be), .wdata(wlanes),
        .busy(bus_busy), .done(bus_done), .rword(bus_word),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data)
    );

    // Response bookkeeping for array-served accesses
    always_ff @(posedge clk) begin
        if (!rst_n) loc_rsp_q <= 1'b0;
        else        loc_rsp_q <= accept && !bus_take;
    end

    // Size, offset and source of the access in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_inst_q <= 1'b0;
            wr_q       <= 1'b0;
            size_q     <= SZ_WORD;
            lo_q       <= 2'd0;
        end else if (accept) begin
            src_inst_q <= i_take;
            wr_q       <= req_write;
            size_q     <= size_e;
            lo_q       <= req_addr[1:0];
        end
    end

    // Response data selection and lane extraction
    always_comb begin
        logic [31:0] word;
        if (loc_rsp_q) word = src_inst_q ? i_word : d_word;
        else           word = bus_word;
        rsp_rdata = wr_q ? 32'd0 : lane_pick(size_q, lo_q, word);
    end

    assign req_ready = !bus_busy;
    assign rsp_valid = loc_rsp_q || bus_done;

    // R9
    local_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !bus_take) |=> (rsp_valid && !bus_valid));

    // R11
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !req_ready);

    // R1
    inst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_rd || d_wr || (accept && bus_take)) |-> !(i_rd || i_wr));

    // R9
    single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_rsp_q && bus_done));
endmodule

// File: tb/tcm_router_bench.sv
`timescale 1ns/1ps
module tcm_router_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IB = 64;
    localparam int DB = 32;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [31:0] ctrl_word = 0, inst_base = 0, data_base = 32'h80;
    logic        req_valid = 0, req_write = 0;
    logic [1:0]  req_size = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic        req_ready, rsp_valid, bus_valid, bus_write;
    logic [31:0] rsp_rdata, bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_ready = 0, bus_rsp_valid = 0;
    logic [31:0] bus_rsp_data = 0;

    int checks = 0, fails = 0;
    bit finished = 0;

    logic [7:0] iref [IB];
    logic [7:0] dref [DB];
    logic [7:0] bref [256];
    logic [7:0] bmem [256];

    int bus_count = 0, bst = 0, bcnt = 0;
    logic [31:0] last_addr = 0, last_wdata = 0;
    logic [3:0]  last_be = 0;
    logic        last_wr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcm_router #(.INST_BYTES(IB), .DATA_BYTES(DB)) u_tcm_router (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .inst_base(inst_base),
        .data_base(data_base), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data)
    );

    // Bus responder: takes a request after a gap, answers after another gap
    always @(negedge clk) begin
        bus_ready = 0;
        bus_rsp_valid = 0;
        if (!rst_n) begin
            bst = 0; bcnt = 0;
        end else if (bst == 0) begin
            if (bus_valid) begin
                if (bcnt >= bus_count % 3) begin
                    bus_ready = 1;
                    last_addr = bus_addr; last_be = bus_be;
                    last_wdata = bus_wdata; last_wr = bus_write;
                    bus_count++; bst = 1; bcnt = 0;
                end else bcnt++;
            end
        end else begin
            if (bcnt >= (bus_count + 1) % 3) begin
                for (int b = 0; b < 4; b++) begin
                    if (last_wr && last_be[b])
                        bmem[{last_addr[7:2], 2'(b)}] = last_wdata[8*b +: 8];
                    bus_rsp_data[8*b +: 8] = bmem[{last_addr[7:2], 2'(b)}];
                end
                bus_rsp_valid = 1; bst = 0; bcnt = 0;
            end else bcnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Routing model from R1, R2, R4, R5, R6
    function automatic int route(logic [31:0] a, bit wr);
        if (ctrl_word[18] && (wr || !ctrl_word[19]) &&
            {1'b0, a} >= {1'b0, inst_base} && {1'b0, a} < {1'b0, inst_base} + 33'(IB)) return 0;
        if (ctrl_word[16] && (wr || !ctrl_word[17]) &&
            {1'b0, a} >= {1'b0, data_base} && {1'b0, a} < {1'b0, data_base} + 33'(DB)) return 1;
        return 2;
    endfunction

    function automatic logic [7:0] rbyte(int t, logic [31:0] a);
        if (t == 0) return iref[a & (IB-1)];
        if (t == 1) return dref[a & (DB-1)];
        return bref[a & 255];
    endfunction

    task automatic access(input bit wr, input int sz, input logic [31:0] a0,
                          input logic [31:0] wd, input string req);
        logic [31:0] a, exp, expbe;
        int t, n, cyc, bc0;
        n = 1 << sz;
        a = a0 & ~32'(n - 1);
        t = route(a, wr);
        exp = 0;
        for (int i = 0; i < n; i++) exp |= 32'(rbyte(t, a + 32'(i))) << (8*i);
        expbe = (sz == 0) ? (32'h1 << a[1:0]) : (sz == 1) ? (32'h3 << {a[1], 1'b0}) : 32'hF;
        bc0 = bus_count;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_size = 2'(sz); req_addr = a; req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 0;
        cyc = 0;
        forever begin
            @(negedge clk); #1;
            cyc++;
            if (rsp_valid) break;
            // R11: no new request taken while a bus access is pending
            chk(req_ready == 0, "R11", "req_ready during bus wait", 32'(req_ready), 0);
            if (cyc > 40) begin
                chk(0, req, "response timeout", 32'(cyc), 0);
                break;
            end
        end
        // R1/R2: went to the bus exactly when no region claimed it
        chk((bus_count != bc0) == (t == 2), req, "bus routing",
            32'(bus_count - bc0), 32'(t == 2));
        // R9: array path answers one cycle after acceptance
        if (t != 2) chk(cyc == 1, "R9", "local latency", 32'(cyc), 1);
        if (!wr) chk(rsp_rdata == exp, req, "read data R8", rsp_rdata, exp);
        if (t == 2 && bus_count != bc0) begin
            // R10: byte enables, address and lane replication on the bus
            chk(last_be == expbe[3:0], "R10", "bus_be", 32'(last_be), expbe);
            chk(last_addr == a, "R10", "bus_addr", last_addr, a);
            if (wr) for (int b = 0; b < 4; b++)
                if (expbe[b])
                    chk(last_wdata[8*b +: 8] == wd[8*(b % n) +: 8], "R10", "bus lane data",
                        32'(last_wdata[8*b +: 8]), 32'(wd[8*(b % n) +: 8]));
        end
        if (wr) for (int i = 0; i < n; i++) begin
            logic [31:0] ab = a + 32'(i);
            if (t == 0) iref[ab & (IB-1)] = wd[8*i +: 8];
            else if (t == 1) dref[ab & (DB-1)] = wd[8*i +: 8];
            else bref[ab & 255] = wd[8*i +: 8];
        end
    endtask

    localparam logic [31:0] BOTH_ON = 32'h0005_0000;

    initial begin
        logic [31:0] rnd;
        for (int i = 0; i < IB; i++) iref[i] = 0;
        for (int i = 0; i < DB; i++) dref[i] = 0;
        for (int i = 0; i < 256; i++) begin bref[i] = 0; bmem[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R7: idle outputs during and after reset
        chk(req_ready == 1, "R7", "req_ready in reset", 32'(req_ready), 1);
        chk(rsp_valid == 0, "R7", "rsp_valid in reset", 32'(rsp_valid), 0);
        chk(bus_valid == 0, "R7", "bus_valid in reset", 32'(bus_valid), 0);
        @(negedge clk); rst_n = 1;
        ctrl_word = BOTH_ON; data_base = 32'h80;

        // R7: both arrays read as zero
        for (int a = 0; a < IB; a += 4) access(0, 2, a, 0, "R7");
        for (int a = 'h80; a < 'h80 + DB; a += 4) access(0, 2, a, 0, "R7");

        // R8: words written, read back as bytes, halves and words
        for (int a = 0; a < IB; a += 4) access(1, 2, a, 32'h0403_0201 * (a + 1) ^ 32'hA5C3_0F96, "R8");
        for (int a = 0; a < IB; a++) access(0, 0, a, 0, "R8");
        for (int a = 0; a < IB; a += 2) access(0, 1, a, 0, "R8");
        for (int a = 0; a < IB; a += 2) access(1, 1, a + 'h80, 32'h1234_0000 | 32'(a * 7), "R8");
        for (int a = 0; a < DB; a += 4) access(0, 2, a + 'h80, 0, "R8");

        // R2/R3: unaligned data base, sweep across both window edges
        data_base = 32'h84;
        for (int a = 'h78; a < 'hAC; a++) access(1, 0, a, 32'(a * 13 + 5), "R2/R3");
        for (int a = 'h78; a < 'hAC; a += 4) access(0, 2, a, 0, "R2/R3");
        for (int a = 'h7E; a < 'hA8; a += 2) access(0, 1, a, 0, "R3");

        // R1: overlapping windows, instruction region wins
        data_base = 32'h20;
        for (int a = 'h18; a < 'h48; a += 4) access(1, 2, a, 32'hC0DE_0000 + 32'(a), "R1");
        for (int a = 'h18; a < 'h48; a += 4) access(0, 2, a, 0, "R1");

        // R4: load mode, reads fall through, writes still captured
        ctrl_word = BOTH_ON | 32'h0008_0000;
        for (int a = 0; a < 'h48; a += 4) access(0, 2, a, 0, "R4");
        for (int a = 0; a < IB; a += 4) access(1, 2, a, 32'h5A00_0000 + 32'(a), "R4");
        ctrl_word = BOTH_ON | 32'h0002_0000;
        for (int a = 'h38; a < 'h48; a += 4) access(1, 2, a, 32'h7700_0000 + 32'(a), "R4");
        for (int a = 0; a < 'h48; a += 4) access(0, 2, a, 0, "R4");
        ctrl_word = BOTH_ON;
        for (int a = 0; a < 'h48; a += 4) access(0, 2, a, 0, "R4");

        // R5/R6: region bits clear, other bits set: everything reaches the bus
        ctrl_word = 32'hFFF0_FFFF;
        for (int a = 0; a < 'h48; a += 4) access(1, 2, a, 32'hDEAD_0000 + 32'(a), "R5/R6");
        for (int a = 0; a < 'h48; a += 4) access(0, 2, a, 0, "R5/R6");
        ctrl_word = BOTH_ON | 32'hFFF0_0000;
        for (int a = 0; a < 'h48; a += 4) access(0, 2, a, 0, "R5/R6");

        // R10: bus lanes for every size and offset
        data_base = 32'h80;
        for (int a = 'hC0; a < 'hD0; a++) access(1, 0, a, 32'(a ^ 'h3C), "R10");
        for (int a = 'hD0; a < 'hE0; a += 2) access(1, 1, a, 32'(a * 'h101), "R10");
        for (int a = 'hC0; a < 'hE0; a++) access(0, 0, a, 0, "R10");
        for (int a = 'hC0; a < 'hE0; a += 2) access(0, 1, a, 0, "R10");
        for (int a = 'hC0; a < 'hE0; a += 4) access(0, 2, a, 0, "R10");

        // Mixed sweep of control bits, bases, sizes and addresses
        rnd = 32'h1357_9BDF;
        for (int k = 0; k < 1500; k++) begin
            rnd ^= rnd << 13; rnd ^= rnd >> 17; rnd ^= rnd << 5;
            if (k % 50 == 0) begin
                ctrl_word = (32'(rnd[3:0]) << 16) | (rnd & 32'hFFF0_FFFF);
                data_base = (rnd[5:4] == 0) ? 32'h20 : (rnd[5:4] == 1) ? 32'h40 :
                            (rnd[5:4] == 2) ? 32'h84 : 32'hE8;
            end
            access(rnd[8], int'(rnd[10:9]) % 3, {24'd0, rnd[23:16]}, rnd ^ 32'h9E37_79B9, "R1/R6");
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule